// File: doc/BRIEF.md
# DMA Descriptor Fetch Unit

This unit loads per-channel transfer descriptors for a five-channel DMA controller. Each descriptor is an eight-byte structure held in ordinary memory. Software sets up the descriptors and the two base pointers first, and then arms a channel. Arming marks the channel as pending. The unit then reads the channel's eight bytes over a byte-wide memory read port and places them in a per-channel register file. It raises that channel's ready flag when the whole descriptor is present.

Channel 0 has its own base pointer. Channels 1 to 4 share a second base pointer, and their descriptors lie back to back from that address, eight bytes apart. Only one descriptor is fetched at a time. Arm requests that arrive while a fetch is in progress wait in a pending mask. Waiting channels are served in ascending channel number. Decoding the descriptor fields and arbitrating for memory are left to neighbouring blocks.

Top module: `desc_fetch`

## Requirements
- R1: After reset, `ready_o` is all zeros, `mem_req_o` is low and every descriptor lane reads zero.
- R2: When the unit is idle, an arm pulse sampled at clock edge A makes `mem_req_o` high after edge A+1.
- R3: For channel 0, the k-th byte read (k = 0..7) is at address `ptr0_i + k`, modulo 2^16.
- R4: For channel n in 1..4, the k-th byte read is at `ptr1_i + 8*(n-1) + k`, modulo 2^16.
- R5: A byte is accepted on a clock edge where `mem_req_o` and `mem_rvalid_i` are both high. Addresses rise by one per accepted byte. While `mem_rvalid_i` is low, the address is held. The pointers are held stable during a fetch.
- R6: Byte k of channel c's descriptor is stored at bits `[64*c + 8*k +: 8]` of `desc_o`.
- R7: Each fetch accepts exactly eight bytes. `mem_req_o` drops on the edge that stores the eighth byte. The channel's ready bit rises on the following edge, unless the channel was re-armed in the meantime.
- R8: An arm pulse clears that channel's ready bit on the edge that samples it. No memory read is issued unless some channel has been armed.
- R9: When several channels are pending as the unit goes idle, the lowest-numbered one is fetched first.
- R10: Re-arming a channel during its own fetch leaves its ready bit low and causes a second complete fetch of that channel.
- R11: `mem_rvalid_i` pulses while `mem_req_o` is low do not change `desc_o` or `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr0_i | input | 16 | Descriptor base address for channel 0 |
| ptr1_i | input | 16 | Base address of the contiguous descriptors for channels 1 to 4 |
| arm_i | input | 5 | One-cycle arm pulses, one bit per channel |
| mem_req_o | output | 1 | Read request, held until a byte is returned |
| mem_addr_o | output | 16 | Byte address of the current read |
| mem_rvalid_i | input | 1 | Read data valid for the current address |
| mem_rdata_i | input | 8 | Read data byte |
| ready_o | output | 5 | Descriptor-loaded flag per channel |
| desc_o | output | 320 | Descriptor register file, 64 bits per channel |

## Verification
The hardest case to reach from the ports is a channel that is re-armed while its own descriptor is still streaming in, combined with other channels that are already pending. In that case the ready flag must stay low and the pending order must still hold. The stimulus arms four channels in the same cycle and waits until the first fetch has begun. It then arms a lower channel, and in a separate run it re-arms the channel being fetched. A stalling read-valid pattern stretches each fetch so that these pulses land in the middle of a transfer. A pointer set near the top of the address space makes the channel 4 address wrap.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/desc_pick.sv
module desc_pick #(
  parameter int N    = 5,
  parameter int CH_W = 3
) (
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic [CH_W-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/desc_base_gen.sv
module desc_base_gen #(
  parameter int N    = 5,
  parameter int AW   = 16,
  parameter int DB   = 8,
  parameter int CH_W = 3
) (
  input  logic [AW-1:0]   ptr0_i,
  input  logic [AW-1:0]   ptr1_i,
  input  logic [CH_W-1:0] sel_i,
  output logic [AW-1:0]   base_o
);
  logic [AW-1:0] base_tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_base
    if (g == 0) begin : g_own
      assign base_tbl[g] = ptr0_i;
    end else begin : g_shared
      assign base_tbl[g] = ptr1_i + AW'(DB * (g - 1));
    end
  end

  always_comb begin
    base_o = base_tbl[0];
    for (int i = 1; i < N; i++) begin
      if (sel_i == CH_W'(i)) base_o = base_tbl[i];
    end
  end
endmodule

// File: rtl/desc_store.sv
module desc_store #(
  parameter int N     = 5,
  parameter int DB    = 8,
  parameter int CH_W  = 3,
  parameter int IDX_W = 3,
  localparam int DW   = DB * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]      data_i,
  output logic [N*DW-1:0] desc_o
);
  logic [DW-1:0] lane_q [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic we;
    assign we = wr_i && (ch_i == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q[g] <= '0;
      else if (we) lane_q[g][idx_i*8 +: 8] <= data_i;
    end

    assign desc_o[g*DW +: DW] = lane_q[g];
  end

  // R11: register file moves only on a write
  a_r11_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(desc_o));
endmodule

// File: rtl/desc_fetch.sv
module desc_fetch
  import desc_fetch_pkg::*;
#(
  parameter int N     = 5,
  parameter int AW    = 16,
  parameter int DB    = 8,
  localparam int CH_W  = (N > 1) ? $clog2(N) : 1,
  localparam int IDX_W = $clog2(DB),
  localparam int DW    = DB * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ptr0_i,
  input  logic [AW-1:0]   ptr1_i,
  input  logic [N-1:0]    arm_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [7:0]      mem_rdata_i,
  output logic [N-1:0]    ready_o,
  output logic [N*DW-1:0] desc_o
);
  fetch_state_e     state_q, state_d;
  logic [CH_W-1:0]  cur_q, cur_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [N-1:0]     pending_q, pending_d;
  logic [N-1:0]     ready_q, ready_d;
  logic [N-1:0]     gnt;
  logic [CH_W-1:0]  gnt_idx;
  logic [N-1:0]     take_mask;
  logic [AW-1:0]    base;
  logic             accept, last;

  desc_pick #(.N(N), .CH_W(CH_W)) u_pick (
    .req_i (pending_q),
    .gnt_o (gnt),
    .idx_o (gnt_idx)
  );

  desc_base_gen #(.N(N), .AW(AW), .DB(DB), .CH_W(CH_W)) u_base (
    .ptr0_i (ptr0_i),
    .ptr1_i (ptr1_i),
    .sel_i  (cur_q),
    .base_o (base)
  );

  desc_store #(.N(N), .DB(DB), .CH_W(CH_W), .IDX_W(IDX_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (accept),
    .ch_i   (cur_q),
    .idx_i  (idx_q),
    .data_i (mem_rdata_i),
    .desc_o (desc_o)
  );

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = base + AW'(idx_q);
  assign accept     = mem_req_o && mem_rvalid_i;
  assign last       = accept && (idx_q == IDX_W'(DB - 1));
  assign take_mask  = (state_q == ST_IDLE) ? gnt : '0;
  assign pending_d  = (pending_q & ~take_mask) | arm_i;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (|pending_q) begin
          state_d = ST_FETCH;
          cur_d   = gnt_idx;
          idx_d   = '0;
        end
      end
      ST_FETCH: begin
        if (accept) begin
          idx_d = idx_q + 1'b1;
          if (last) state_d = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // ready set after completion unless re-armed meanwhile; arm always clears
  always_comb begin
    ready_d = ready_q;
    for (int i = 0; i < N; i++) begin
      if (state_q == ST_DONE && cur_q == CH_W'(i) && !pending_q[i]) ready_d[i] = 1'b1;
    end
    ready_d = ready_d & ~arm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      idx_q     <= '0;
      pending_q <= '0;
      ready_q   <= '0;
    end else begin
      state_q   <= state_d;
      cur_q     <= cur_d;
      idx_q     <= idx_d;
      pending_q <= pending_d;
      ready_q   <= ready_d;
    end
  end

  assign ready_o = ready_q;

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !last |=> mem_addr_o == $past(mem_addr_o) + AW'(1));

  a_r7_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> !mem_req_o);

  a_r7_ready_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(ready_o & ~$past(ready_o)) |-> $past(state_q == ST_DONE));

  a_r8_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |arm_i |=> (ready_o & $past(arm_i)) == '0);

  a_r8_req_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(|pending_q));

  a_r9_pick_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && |pending_q |-> ((gnt - 1'b1) & pending_q) == '0 && (gnt & pending_q) != '0);
endmodule

// File: tb/desc_fetch_test.sv
module desc_fetch_test;
  localparam int N  = 5;
  localparam int AW = 16;
  localparam int DB = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   ptr0 = '0, ptr1 = '0;
  logic [N-1:0]    arm = '0;
  logic            mem_req;
  logic [AW-1:0]   mem_addr;
  logic            mem_rvalid;
  logic [7:0]      mem_rdata;
  logic [N-1:0]    ready;
  logic [N*64-1:0] desc;

  int checks = 0, errors = 0;
  int cyc = 0;
  int stall_mode = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_f(logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] base_of(int c);
    if (c == 0) return ptr0;
    return ptr1 + 16'(8 * (c - 1));
  endfunction

  assign mem_rvalid = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  assign mem_rdata  = mem_f(mem_addr);

  desc_fetch uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ptr0_i       (ptr0),
    .ptr1_i       (ptr1),
    .arm_i        (arm),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .ready_o      (ready),
    .desc_o       (desc)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fetch monitor: expected channel order, addresses, byte count, ready timing
  int ord [16];
  int ord_len = 0, ord_idx = 0;
  int cur_ch = 0, cnt = 0, rdy_stage = 0;
  bit exp_rdy = 1'b0, prev_req = 1'b0, mon_en = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (rdy_stage == 1) begin
        chk(ready[cur_ch] == 1'b0, "R7 ready early", 64'(ready[cur_ch]), 64'd0);
        rdy_stage = 2;
      end else if (rdy_stage == 2) begin
        chk(ready[cur_ch] == exp_rdy, exp_rdy ? "R7 ready rise" : "R10 ready held low",
            64'(ready[cur_ch]), 64'(exp_rdy));
        rdy_stage = 0;
      end
      if (mem_req && !prev_req) begin
        if (ord_idx < ord_len) cur_ch = ord[ord_idx];
        else chk(1'b0, "R8 unexpected fetch", 64'(ord_idx), 64'(ord_len));
        ord_idx++;
        cnt = 0;
      end
      if (mem_req && mem_rvalid) begin
        chk(mem_addr == base_of(cur_ch) + 16'(cnt), (cur_ch == 0) ? "R3 addr" : "R4/R5/R9 addr",
            64'(mem_addr), 64'(base_of(cur_ch) + 16'(cnt)));
        cnt++;
        if (cnt == 8) begin
          rdy_stage = 1;
          exp_rdy   = 1'b1;
          for (int j = ord_idx; j < ord_len; j++) if (ord[j] == cur_ch) exp_rdy = 1'b0;
        end
      end
      if (!mem_req && prev_req) chk(cnt == 8, "R7 byte count", 64'(cnt), 64'd8);
      prev_req = mem_req;
    end
  end

  task automatic pulse_arm(input logic [N-1:0] m);
    @(negedge clk) arm = m;
    @(negedge clk) arm = '0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!(ord_idx >= ord_len && !mem_req && rdy_stage == 0) && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk(t < 400, "R7 fetch completes", 64'(t), 64'd400);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_desc(input int c);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      a = base_of(c) + 16'(k);
      chk(desc[c*64 + 8*k +: 8] == mem_f(a), "R6 descriptor byte", 64'(desc[c*64 + 8*k +: 8]), 64'(mem_f(a)));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] p0s [3];
    logic [15:0] p1s [3];
    logic [N*64-1:0] snap;
    logic [N-1:0] rsnap;
    p0s[0] = 16'h1000; p1s[0] = 16'h2000;
    p0s[1] = 16'h0123; p1s[1] = 16'h00F0;
    p0s[2] = 16'hFFFC; p1s[2] = 16'hFFEC;

    repeat (3) @(negedge clk);
    chk(ready == '0, "R1 ready", 64'(ready), 64'd0);
    chk(mem_req == 1'b0, "R1 req", 64'(mem_req), 64'd0);
    chk(desc == '0, "R1 desc", 64'(desc[63:0]), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    chk(ready == '0 && !mem_req, "R1 after release", 64'(ready), 64'd0);

    // R2 start latency
    ptr0 = p0s[0]; ptr1 = p1s[0];
    ord[0] = 2; ord_len = 1; ord_idx = 0;
    @(negedge clk) arm = 5'b00100;
    @(negedge clk) arm = '0;
    chk(mem_req == 1'b0, "R2 req one edge after arm", 64'(mem_req), 64'd0);
    @(negedge clk);
    chk(mem_req == 1'b1, "R2 req two edges after arm", 64'(mem_req), 64'd1);
    wait_done();
    check_desc(2);

    // sweep: pointer sets x stall modes x channels
    for (int ps = 0; ps < 3; ps++) begin
      for (int sm = 0; sm < 2; sm++) begin
        for (int c = 0; c < N; c++) begin
          ptr0 = p0s[ps]; ptr1 = p1s[ps]; stall_mode = sm;
          ord[0] = c; ord_len = 1; ord_idx = 0;
          pulse_arm(5'(1 << c));
          wait_done();
          check_desc(c);
          chk(ready[c] == 1'b1, "R7 ready held", 64'(ready[c]), 64'd1);
        end
      end
    end

    // R8: arm clears ready on the sampling edge
    ord[0] = 3; ord_len = 1; ord_idx = 0;
    @(negedge clk) arm = 5'b01000;
    @(negedge clk) arm = '0;
    chk(ready[3] == 1'b0, "R8 arm clears ready", 64'(ready[3]), 64'd0);
    wait_done();
    check_desc(3);

    // R9: simultaneous arms plus a lower one during the first fetch
    ptr0 = p0s[0]; ptr1 = p1s[0]; stall_mode = 1;
    ord[0] = 1; ord[1] = 0; ord[2] = 2; ord[3] = 3; ord[4] = 4;
    ord_len = 5; ord_idx = 0;
    @(negedge clk) arm = 5'b11110;
    @(negedge clk) arm = '0;
    while (!mem_req) @(negedge clk);
    pulse_arm(5'b00001);
    wait_done();
    for (int c = 0; c < N; c++) check_desc(c);
    chk(ready == 5'b11111, "R9 all ready", 64'(ready), 64'h1f);

    // R10: re-arm the channel being fetched
    ptr0 = p0s[1]; ptr1 = p1s[1];
    ord[0] = 2; ord[1] = 2; ord_len = 2; ord_idx = 0;
    pulse_arm(5'b00100);
    while (!mem_req) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b1, "R10 still fetching", 64'(mem_req), 64'd1);
    pulse_arm(5'b00100);
    wait_done();
    chk(ready[2] == 1'b1, "R10 ready after refetch", 64'(ready[2]), 64'd1);
    check_desc(2);

    // R11 / R8: idle with valid pulses and changed pointers
    stall_mode = 1;
    snap = desc; rsnap = ready;
    ptr0 = 16'h4444; ptr1 = 16'h5555;
    repeat (12) begin
      @(negedge clk);
      chk(!mem_req, "R8 no fetch without arm", 64'(mem_req), 64'd0);
    end
    chk(desc == snap, "R11 desc unchanged", 64'(desc[191:128]), 64'(snap[191:128]));
    chk(ready == rsnap, "R11 ready unchanged", 64'(ready), 64'(rsnap));
    stall_mode = 0;
    repeat (6) @(negedge clk);
    chk(desc == snap && !mem_req, "R11 desc unchanged valid high", 64'(desc[63:0]), 64'(snap[63:0]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule